// File: doc/BRIEF.md
# Symbol Boundary Aligner with Link Synchronization

This block sits between a deserializer and a pair of 8b/10b symbol decoders. On every recovered-clock cycle it takes a raw 20-bit word. The earliest bit on the line is in bit 0. The boundary of that word has no fixed relation to the 10-bit symbol boundary of the line code. The block joins the new word to the previous one and searches 20 candidate bit positions for the comma that only a special control symbol carries. It then puts out a registered, aligned 20-bit word as two 10-bit symbols, with the earlier symbol in the low half.

The decoders classify each symbol pair and return the result as a 3-bit code: nothing this cycle, idle, carrier extend, data, error propagation, or invalid. A three-state link machine uses these codes to acquire the link, run it, and question it, using separate counters for consecutive and non-consecutive events. The machine also controls realignment. The aligner may move the boundary during acquisition. Once the link is up and a comma has arrived exactly on the current boundary, the boundary is frozen. A single bit error that happens to look like a comma therefore cannot shift it. The boundary is released again only when synchronization is lost or the block is reset.

Top module: `link_align_sync`

## Requirements
- R1: While `rst` is high on a clock edge, the block resets after that edge as follows: `link_state` goes to 0 (acquire), `realign_en` to 1, `align_off` to 0, `sync_lost` to 0, and both symbol outputs to 0. The state code 3 never appears. The state codes are 0 for acquire, 1 for synchronized and 2 for check.
- R2: A comma is a 7-bit window whose value, read as bits [6:0] with bit 0 first on the line, is 7'b1111100 or 7'b0000011. Window p is bits p to p+6 of {raw_word, previous raw_word}, for p from 0 to 19. When `realign_en` is high and any window matches, `align_off` takes the lowest matching p at the clock edge. The word put out at that same edge already uses the new offset.
- R3: After each edge, {sym_hi, sym_lo} holds bits off to off+19 of {raw_word, previous raw_word} as they were at that edge, where off is the value `align_off` shows after the edge.
- R4: In acquire, three consecutive idle (class 1) or carrier-extend (class 2) words move the link to synchronized. An invalid word clears the run. Classes 5, 6 and 7 count as invalid. Class 0 leaves the run unchanged.
- R5: In acquire, one data word (class 3) or one error-propagation word (class 4) moves the link to synchronized on the next edge.
- R6: In synchronized, an invalid word moves the link to check. Valid words and class 0 keep it in synchronized. The link never goes from synchronized straight to acquire.
- R7: In check, four consecutive valid words (classes 1 to 4) return the link to synchronized. An invalid word restarts that run.
- R8: In check, the third invalid word since entering check moves the link to acquire, and these invalid words need not be consecutive. `sync_lost` is high for exactly the one cycle after that transition.
- R9: `realign_en` falls when the link is out of acquire and a comma is found at window `align_off`. While it is low, `align_off` holds its value and commas at other positions do not move it.
- R10: Entering acquire through loss of synchronization sets `realign_en` again, and a later comma then sets a new offset.
- R11: A synchronous reset during synchronized operation with realignment frozen has the same effect as R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_word | input | 20 | Unaligned word, earliest line bit in bit 0 |
| word_cls | input | 3 | Decoder class of a word: 0 none, 1 idle, 2 carrier extend, 3 data, 4 error propagation, 5 to 7 invalid |
| sym_lo | output | 10 | Aligned earlier symbol |
| sym_hi | output | 10 | Aligned later symbol |
| align_off | output | 5 | Current boundary offset, 0 to 19 |
| link_state | output | 2 | 0 acquire, 1 synchronized, 2 check |
| sync_lost | output | 1 | One-cycle pulse on loss of synchronization |
| realign_en | output | 1 | High while the boundary may still move |

## Verification
The assertions check on every cycle the properties that hold for any input stream. The offset stays in range and does not change while realignment is frozen. An invalid word never lets acquire exit. A payload word in acquire and an invalid word in synchronized each take effect on the next edge. Synchronized never falls straight to acquire. Acquire always has realignment enabled, and the sync-lost pulse lasts one cycle. The bench scenarios cover the behaviour that depends on history or bit patterns: counting of consecutive and non-consecutive events in each state, lowest-offset priority between two commas, detection of the complemented comma, freezing of the boundary against a comma placed off the boundary, and release of the boundary after loss of sync or reset.

// File: rtl/link_align_pkg.sv
package link_align_pkg;

  typedef enum logic [1:0] {
    LNK_ACQ   = 2'd0,
    LNK_SYNC  = 2'd1,
    LNK_CHECK = 2'd2
  } link_st_t;

  localparam logic [2:0] CLS_NONE = 3'd0;
  localparam logic [2:0] CLS_IDLE = 3'd1;
  localparam logic [2:0] CLS_CEXT = 3'd2;
  localparam logic [2:0] CLS_DATA = 3'd3;
  localparam logic [2:0] CLS_ERRP = 3'd4;
  localparam logic [2:0] CLS_BAD  = 3'd5;

  localparam int         COMMA_LEN = 7;
  // bit 0 is the first bit on the line
  localparam logic [6:0] COMMA_POS = 7'b1111100;
  localparam logic [6:0] COMMA_NEG = 7'b0000011;

endpackage

// File: rtl/comma_scan.sv
module comma_scan
  import link_align_pkg::*;
#(
  parameter  int WORD_W = 20,
  localparam int WIN_W  = 2 * WORD_W,
  localparam int OFF_W  = $clog2(WORD_W)
) (
  input  logic [WIN_W-1:0]  win,
  output logic [WORD_W-1:0] hits,
  output logic              found,
  output logic [OFF_W-1:0]  first_off
);

  for (genvar k = 0; k < WORD_W; k++) begin : g_win
    assign hits[k] = (win[k +: COMMA_LEN] == COMMA_POS) ||
                     (win[k +: COMMA_LEN] == COMMA_NEG);
  end

  assign found = |hits;

  // lowest matching position wins
  always_comb begin
    first_off = '0;
    for (int k = WORD_W - 1; k >= 0; k--) begin
      if (hits[k]) first_off = OFF_W'(k);
    end
  end

endmodule

// File: rtl/word_aligner.sv
module word_aligner
  import link_align_pkg::*;
#(
  parameter  int SYM_W  = 10,
  localparam int WORD_W = 2 * SYM_W,
  localparam int OFF_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] raw_word,
  input  logic              realign_en,
  output logic [SYM_W-1:0]  sym_lo,
  output logic [SYM_W-1:0]  sym_hi,
  output logic [OFF_W-1:0]  align_off,
  output logic              comma_at_cur
);

  logic [WORD_W-1:0]   prev_q;
  logic [OFF_W-1:0]    off_q;
  logic [WORD_W-1:0]   out_q;
  logic [2*WORD_W-1:0] win;
  logic [WORD_W-1:0]   hits;
  logic                found;
  logic [OFF_W-1:0]    first_off;
  logic [OFF_W-1:0]    sel;
  logic [WORD_W-1:0]   cand [WORD_W];

  assign win = {raw_word, prev_q};

  comma_scan #(.WORD_W(WORD_W)) i_scan (
    .win       (win),
    .hits      (hits),
    .found     (found),
    .first_off (first_off)
  );

  for (genvar k = 0; k < WORD_W; k++) begin : g_cand
    assign cand[k] = win[k +: WORD_W];
  end

  assign sel          = (realign_en && found) ? first_off : off_q;
  assign comma_at_cur = hits[off_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      off_q  <= '0;
      out_q  <= '0;
    end else begin
      prev_q <= raw_word;
      off_q  <= sel;
      out_q  <= cand[sel];
    end
  end

  assign sym_lo    = out_q[SYM_W-1:0];
  assign sym_hi    = out_q[WORD_W-1:SYM_W];
  assign align_off = off_q;

  // R9: a frozen boundary never moves
  assert_hold_off_R9: assert property (@(posedge clk) disable iff (rst)
    !realign_en |=> align_off == $past(align_off));

  // R2: offset stays within the word
  assert_off_range_R2: assert property (@(posedge clk) disable iff (rst)
    align_off < OFF_W'(WORD_W));

endmodule

// File: rtl/link_sync_fsm.sv
module link_sync_fsm
  import link_align_pkg::*;
#(
  parameter  int ACQ_IDLES = 3,
  parameter  int CHK_GOOD  = 4,
  parameter  int CHK_BAD   = 3,
  localparam int ACQ_CW    = $clog2(ACQ_IDLES + 1),
  localparam int GOOD_CW   = $clog2(CHK_GOOD + 1),
  localparam int BAD_CW    = $clog2(CHK_BAD + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] word_cls,
  input  logic       comma_at_cur,
  output logic [1:0] link_state,
  output logic       sync_lost,
  output logic       realign_en
);

  link_st_t           st_q, st_n;
  logic [ACQ_CW-1:0]  acq_q, acq_n;
  logic [GOOD_CW-1:0] good_q, good_n;
  logic [BAD_CW-1:0]  bad_q, bad_n;
  logic               lost_q, lost_n;
  logic               rlg_q, rlg_n;
  logic               is_fill, is_pay, is_bad, is_valid;

  assign is_fill  = (word_cls == CLS_IDLE) || (word_cls == CLS_CEXT);
  assign is_pay   = (word_cls == CLS_DATA) || (word_cls == CLS_ERRP);
  assign is_bad   = (word_cls >= CLS_BAD);
  assign is_valid = is_fill || is_pay;

  always_comb begin
    st_n   = st_q;
    acq_n  = acq_q;
    good_n = good_q;
    bad_n  = bad_q;
    lost_n = 1'b0;
    unique case (st_q)
      LNK_ACQ: begin
        if (is_pay) begin
          st_n  = LNK_SYNC;
          acq_n = '0;
        end else if (is_fill) begin
          if (acq_q == ACQ_CW'(ACQ_IDLES - 1)) begin
            st_n  = LNK_SYNC;
            acq_n = '0;
          end else begin
            acq_n = acq_q + ACQ_CW'(1);
          end
        end else if (is_bad) begin
          acq_n = '0;
        end
      end
      LNK_SYNC: begin
        if (is_bad) begin
          st_n   = LNK_CHECK;
          good_n = '0;
          bad_n  = '0;
        end
      end
      LNK_CHECK: begin
        if (is_bad) begin
          good_n = '0;
          if (bad_q == BAD_CW'(CHK_BAD - 1)) begin
            st_n   = LNK_ACQ;
            bad_n  = '0;
            acq_n  = '0;
            lost_n = 1'b1;
          end else begin
            bad_n = bad_q + BAD_CW'(1);
          end
        end else if (is_valid) begin
          if (good_q == GOOD_CW'(CHK_GOOD - 1)) begin
            st_n   = LNK_SYNC;
            good_n = '0;
          end else begin
            good_n = good_q + GOOD_CW'(1);
          end
        end
      end
      default: st_n = LNK_ACQ;
    endcase
  end

  always_comb begin
    rlg_n = rlg_q;
    if (st_n == LNK_ACQ && st_q != LNK_ACQ) rlg_n = 1'b1;
    else if (st_q != LNK_ACQ && comma_at_cur) rlg_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= LNK_ACQ;
      acq_q  <= '0;
      good_q <= '0;
      bad_q  <= '0;
      lost_q <= 1'b0;
      rlg_q  <= 1'b1;
    end else begin
      st_q   <= st_n;
      acq_q  <= acq_n;
      good_q <= good_n;
      bad_q  <= bad_n;
      lost_q <= lost_n;
      rlg_q  <= rlg_n;
    end
  end

  assign link_state = st_q;
  assign sync_lost  = lost_q;
  assign realign_en = rlg_q;

  assert_legal_state_R1: assert property (@(posedge clk) disable iff (rst)
    link_state != 2'd3);

  assert_acq_bad_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == LNK_ACQ && is_bad) |=> st_q == LNK_ACQ);

  assert_acq_payload_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == LNK_ACQ && is_pay) |=> st_q == LNK_SYNC);

  assert_sync_bad_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == LNK_SYNC && is_bad) |=> st_q == LNK_CHECK);

  assert_sync_no_drop_R6: assert property (@(posedge clk) disable iff (rst)
    st_q == LNK_SYNC |=> st_q != LNK_ACQ);

  assert_lost_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    sync_lost |=> !sync_lost);

  assert_lost_in_acq_R8: assert property (@(posedge clk) disable iff (rst)
    sync_lost |-> st_q == LNK_ACQ);

  assert_acq_realign_R10: assert property (@(posedge clk) disable iff (rst)
    st_q == LNK_ACQ |-> realign_en);

endmodule

// File: rtl/link_align_sync.sv
module link_align_sync #(
  parameter  int SYM_W     = 10,
  parameter  int ACQ_IDLES = 3,
  parameter  int CHK_GOOD  = 4,
  parameter  int CHK_BAD   = 3,
  localparam int WORD_W    = 2 * SYM_W,
  localparam int OFF_W     = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] raw_word,
  input  logic [2:0]        word_cls,
  output logic [SYM_W-1:0]  sym_lo,
  output logic [SYM_W-1:0]  sym_hi,
  output logic [OFF_W-1:0]  align_off,
  output logic [1:0]        link_state,
  output logic              sync_lost,
  output logic              realign_en
);

  logic comma_at_cur;

  word_aligner #(.SYM_W(SYM_W)) i_aligner (
    .clk          (clk),
    .rst          (rst),
    .raw_word     (raw_word),
    .realign_en   (realign_en),
    .sym_lo       (sym_lo),
    .sym_hi       (sym_hi),
    .align_off    (align_off),
    .comma_at_cur (comma_at_cur)
  );

  link_sync_fsm #(
    .ACQ_IDLES (ACQ_IDLES),
    .CHK_GOOD  (CHK_GOOD),
    .CHK_BAD   (CHK_BAD)
  ) i_fsm (
    .clk          (clk),
    .rst          (rst),
    .word_cls     (word_cls),
    .comma_at_cur (comma_at_cur),
    .link_state   (link_state),
    .sync_lost    (sync_lost),
    .realign_en   (realign_en)
  );

endmodule

// File: tb/test_link_align_sync.sv
`timescale 1ns/100ps
module test_link_align_sync;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] raw_word = '0;
  logic [2:0]  word_cls = '0;
  logic [9:0]  sym_lo, sym_hi;
  logic [4:0]  align_off;
  logic [1:0]  link_state;
  logic        sync_lost, realign_en;

  int          checks = 0;
  int          errors = 0;
  logic [19:0] prev_drv = '0;
  logic [39:0] win_exp  = '0;
  logic        done     = 1'b0;

  always #2.5 clk = ~clk;

  link_align_sync i_link_align_sync (
    .clk(clk), .rst(rst), .raw_word(raw_word), .word_cls(word_cls),
    .sym_lo(sym_lo), .sym_hi(sym_hi), .align_off(align_off),
    .link_state(link_state), .sync_lost(sync_lost), .realign_en(realign_en)
  );

  // packed {class[2:0], expected state[1:0], expected sync_lost}
  localparam int NVEC = 25;
  localparam logic [5:0] FSM_VEC [NVEC] = '{
    {3'd1, 2'd0, 1'b0}, {3'd1, 2'd0, 1'b0}, {3'd5, 2'd0, 1'b0},
    {3'd1, 2'd0, 1'b0}, {3'd2, 2'd0, 1'b0}, {3'd0, 2'd0, 1'b0},
    {3'd1, 2'd1, 1'b0}, {3'd3, 2'd1, 1'b0}, {3'd5, 2'd2, 1'b0},
    {3'd1, 2'd2, 1'b0}, {3'd3, 2'd2, 1'b0}, {3'd5, 2'd2, 1'b0},
    {3'd1, 2'd2, 1'b0}, {3'd2, 2'd2, 1'b0}, {3'd3, 2'd2, 1'b0},
    {3'd4, 2'd1, 1'b0}, {3'd5, 2'd2, 1'b0}, {3'd5, 2'd2, 1'b0},
    {3'd3, 2'd2, 1'b0}, {3'd5, 2'd2, 1'b0}, {3'd1, 2'd2, 1'b0},
    {3'd6, 2'd0, 1'b1}, {3'd0, 2'd0, 1'b0}, {3'd4, 2'd1, 1'b0},
    {3'd2, 2'd1, 1'b0}
  };

  localparam logic [19:0] IDLE_W = {10'h155, 10'h17C};
  localparam logic [19:0] C3     = 20'(7'b1111100) << 3;
  localparam logic [19:0] DUAL   = (20'(7'b1111100) << 3) | (20'(7'b1111100) << 13);
  localparam logic [19:0] N9     = 20'(7'b0000011) << 9;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [19:0] rw, input logic [2:0] c);
    @(negedge clk);
    raw_word = rw;
    word_cls = c;
    win_exp  = {rw, prev_drv};
    prev_drv = rw;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; raw_word = '0; word_cls = '0; prev_drv = '0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_sym(input string req, input int off);
    logic [19:0] e;
    e = win_exp[off +: 20];
    check(req, {sym_hi, sym_lo}, e);
  endtask

  task automatic check_reset_state(input string req);
    check(req, link_state, 2'd0);
    check(req, realign_en, 1'b1);
    check(req, align_off, 5'd0);
    check(req, sync_lost, 1'b0);
    check(req, {sym_hi, sym_lo}, 20'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] r;
    do_reset();
    check_reset_state("R1 reset");

    // link state walk: R4/R5/R6/R7/R8
    for (int i = 0; i < NVEC; i++) begin
      step(20'd0, FSM_VEC[i][5:3]);
      check($sformatf("R4/R5/R6/R7/R8 row %0d state", i), link_state, FSM_VEC[i][2:1]);
      check($sformatf("R8 row %0d lost", i), sync_lost, FSM_VEC[i][0]);
    end

    // R2, R3: idle stream placed at offset 7
    do_reset();
    step(20'd0, 3'd0);
    r = 20'({IDLE_W, 20'd0} >> 13);
    step(r, 3'd0);
    r = 20'({IDLE_W, IDLE_W} >> 13);
    step(r, 3'd0);
    check("R2 offset 7", align_off, 5'd7);
    check("R3 low symbol comma", sym_lo, 10'h17C);
    check("R3 high symbol", sym_hi, 10'h155);
    step(r, 3'd0);
    check_sym("R3 steady word", 7);

    // R2: two commas, lowest position wins
    step(20'd0, 3'd0);
    step(DUAL, 3'd0);
    step(20'd0, 3'd0);
    check("R2 priority offset", align_off, 5'd3);
    check_sym("R2 word aligned same edge", 3);

    // R2: complemented comma
    step(N9, 3'd0);
    step(20'd0, 3'd0);
    check("R2 complement offset", align_off, 5'd9);
    check_sym("R3 complement word", 9);

    // R9: freeze after an on-boundary comma with link up
    step(N9, 3'd3);
    check("R5 data enters sync", link_state, 2'd1);
    step(20'd0, 3'd0);
    check("R9 realign frozen", realign_en, 1'b0);
    step(C3, 3'd0);
    step(20'd0, 3'd0);
    check("R9 offset held", align_off, 5'd9);
    check_sym("R9 off-boundary comma ignored", 9);

    // R10: loss of sync releases the boundary
    step(20'd0, 3'd5);
    check("R6 into check", link_state, 2'd2);
    step(20'd0, 3'd5);
    step(20'd0, 3'd7);
    step(20'd0, 3'd5);
    check("R8 back to acquire", link_state, 2'd0);
    check("R8 lost pulse", sync_lost, 1'b1);
    check("R10 realign released", realign_en, 1'b1);
    step(C3, 3'd0);
    step(20'd0, 3'd0);
    check("R10 new offset", align_off, 5'd3);
    check("R8 pulse ended", sync_lost, 1'b0);

    // R11: reset while frozen
    step(C3, 3'd3);
    step(20'd0, 3'd0);
    check("R11 frozen before reset", realign_en, 1'b0);
    do_reset();
    check_reset_state("R11 reset while synced");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule